// File: doc/BRIEF.md
# Codec Serial Port

A full-duplex synchronous serial port that links a processor core to an audio or telephony codec. Receive and transmit run independently. Each has its own bit clock and frame sync line. All five external serial lines pass through a synchronizer into the core clock domain, and the port acts only on edges detected after synchronization. Words are 16 bits or 8 bits long, selected by one mode input. Bits travel most significant first.

On the receive side, a frame sync seen high on a falling edge of the receive clock opens a word. The following falling edges shift in the data bits. When the last bit arrives, the finished word is copied to a parallel holding register for the core, and a one-cycle interrupt pulse is raised. On the transmit side, the core writes a word into a holding register. When a frame starts, that word moves into the shift register and a one-cycle interrupt pulse tells the core it may write the next word. The transmit frame sync either comes from outside or is produced by the port itself, chosen by a mode input. If the core writes nothing new before the next frame, the same word is sent again.

Top module: `codec_sport`

## Requirements
- R1: After reset, `rx_word`, `rx_irq`, `tx_irq`, `tx_sdata` and `tx_fsync_out` are all 0.
- R2: With `wide_word`=1, a receive frame sync sampled high on a falling edge of `rx_sclk` opens a word. The next 16 falling edges capture `rx_sdata`, most significant bit first. The completed word then appears on `rx_word`.
- R3: With `wide_word`=0, a receive word is 8 bits. It is placed in `rx_word[7:0]`, with `rx_word[15:8]` = 0.
- R4: `rx_irq` is a single-cycle pulse, raised in the cycle `rx_word` takes a new word. `rx_word` changes at no other time.
- R5: With `fs_internal`=0, a transmit clock rising edge that sees `tx_fsync_in` high starts a frame. The held word is loaded, its most significant bit appears on `tx_sdata`, and each following rising edge presents the next bit.
- R6: `tx_irq` is a single-cycle pulse, raised once per frame when the held word is moved into the shift register.
- R7: If `tx_wr` was not asserted since the last load, the next frame sends the previous word again.
- R8: With `fs_internal`=1, on a rising edge while idle the port drives `tx_fsync_out` high for exactly one transmit clock period. The word follows from the next rising edge, and a new sync period follows each last bit, so frames repeat. With `fs_internal`=0, `tx_fsync_out` never rises.
- R9: With `wide_word`=0, the transmitter sends `tx_wdata[7:0]`, bit 7 first, for 8 bits.
- R10: `tx_sdata` changes only after a detected transmit clock rising edge. It returns to 0 at the rising edge after the last bit when no new frame starts there.
- R11: Every serial clock edge takes effect at the outputs on the third core clock edge after the input changes. This is two synchronizer stages plus the edge-detect register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Receive serial data |
| tx_sclk | input | 1 | Transmit bit clock |
| tx_fsync_in | input | 1 | External transmit frame sync |
| fs_internal | input | 1 | 1: port generates the transmit frame sync; 0: the sync comes from `tx_fsync_in` |
| wide_word | input | 1 | 1: 16-bit words; 0: 8-bit words |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 16 | Word to transmit |
| tx_sdata | output | 1 | Transmit serial data |
| tx_fsync_out | output | 1 | Transmit frame sync produced by the port |
| rx_word | output | 16 | Last complete received word |
| rx_irq | output | 1 | Receive-done pulse |
| tx_irq | output | 1 | Transmit-load pulse |

## Verification
A wrong bit counter would show within one frame. The word on `rx_word` would be shifted by whole bits. The serial stream on `tx_sdata` would start or stop one bit early or late. `tx_irq` would come at the wrong rising edge. A stale or lost holding register would show on the next frame, as the wrong repeated word. The reference model tracks every core cycle, so a timing slip of even one synchronizer stage is caught at the first cycle where an output differs from the model.

// File: rtl/csp_pkg.sv
package csp_pkg;

   // Transmit sequencer states
   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_SYNC  = 2'd1,
      TX_SHIFT = 2'd2
   } tx_state_t;

endpackage

// File: rtl/csp_sync.sv
// Multi-stage level synchronizer for one asynchronous line.
module csp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("csp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign lvl = chain[STAGES-1];

endmodule

// File: rtl/csp_rx.sv
// Receive section: falling-edge sampling, word assembly, hand-off.
module csp_rx #(
   parameter int DATA_W  = 16,
   parameter int SHORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_lvl,
   input  logic              fs_lvl,
   input  logic              din_lvl,
   input  logic              wide,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_done
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_WIDE  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);
   localparam logic [DATA_W-1:0] SHORT_MASK = {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

   logic              sclk_q;
   logic              bit_fall;
   logic              active;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  last_idx;
   logic [DATA_W-1:0] sh;
   logic [DATA_W-1:0] next_sh;

   assign bit_fall = sclk_q & ~sclk_lvl;
   assign last_idx = wide ? LAST_WIDE : LAST_SHORT;
   assign next_sh  = {sh[DATA_W-2:0], din_lvl};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         active  <= 1'b0;
         cnt     <= '0;
         sh      <= '0;
         rx_word <= '0;
         rx_done <= 1'b0;
      end else begin
         sclk_q  <= sclk_lvl;
         rx_done <= 1'b0;
         if (bit_fall) begin
            if (!active) begin
               if (fs_lvl) begin
                  active <= 1'b1;
                  cnt    <= '0;
               end
            end else begin
               sh <= next_sh;
               if (cnt == last_idx) begin
                  active  <= 1'b0;
                  rx_done <= 1'b1;
                  rx_word <= wide ? next_sh : (next_sh & SHORT_MASK);
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   // R4: completion is a lone pulse
   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R4: the parallel word moves only together with the completion pulse
   a_r4_word_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_word) |-> rx_done);

   // R3: short words leave the upper field clear
   a_r3_short_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !$past(wide)) |-> (rx_word[DATA_W-1:SHORT_W] == '0));

   // R2: a word completes only after a detected falling edge
   a_r2_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> $past(bit_fall));

endmodule

// File: rtl/csp_tx.sv
// Transmit section: holding register, frame start, serializer.
module csp_tx #(
   parameter int DATA_W  = 16,
   parameter int SHORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_lvl,
   input  logic              fs_lvl,
   input  logic              int_mode,
   input  logic              wide,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              dout,
   output logic              fs_out,
   output logic              load_done
);

   import csp_pkg::*;

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_WIDE  = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);

   tx_state_t         state;
   logic              sclk_q;
   logic              bit_rise;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  last_idx;
   logic [DATA_W-1:0] hold;
   logic [DATA_W-1:0] sh;
   logic              hold_msb;
   logic              next_bit;
   logic              frame_free;

   assign bit_rise   = sclk_lvl & ~sclk_q;
   assign last_idx   = wide ? LAST_WIDE : LAST_SHORT;
   assign hold_msb   = wide ? hold[DATA_W-1] : hold[SHORT_W-1];
   assign next_bit   = wide ? sh[DATA_W-2]   : sh[SHORT_W-2];
   assign frame_free = (state == TX_IDLE) || ((state == TX_SHIFT) && (cnt == last_idx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= TX_IDLE;
         sclk_q    <= 1'b0;
         cnt       <= '0;
         hold      <= '0;
         sh        <= '0;
         dout      <= 1'b0;
         fs_out    <= 1'b0;
         load_done <= 1'b0;
      end else begin
         sclk_q    <= sclk_lvl;
         load_done <= 1'b0;
         if (wr) hold <= wdata;
         if (bit_rise) begin
            if ((state == TX_SYNC) || (frame_free && !int_mode && fs_lvl)) begin
               sh        <= hold;
               cnt       <= '0;
               dout      <= hold_msb;
               load_done <= 1'b1;
               fs_out    <= 1'b0;
               state     <= TX_SHIFT;
            end else if (frame_free) begin
               dout <= 1'b0;
               if (int_mode) begin
                  fs_out <= 1'b1;
                  state  <= TX_SYNC;
               end else begin
                  state  <= TX_IDLE;
               end
            end else begin
               sh   <= {sh[DATA_W-2:0], 1'b0};
               cnt  <= cnt + 1'b1;
               dout <= next_bit;
            end
         end
      end
   end

   // R6: load notification is a lone pulse
   a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> !load_done);

   // R10: serial output moves only after a detected rising edge
   a_r10_dout_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> $past(bit_rise));

   // R8: the port raises its own sync only in internal mode
   a_r8_fs_internal_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fs_out) |-> $past(int_mode));

   // R8: generated sync lasts one serial period
   a_r8_fs_one_period: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_out && bit_rise) |=> !fs_out);

endmodule

// File: rtl/codec_sport.sv
// Full-duplex synchronous codec serial port, top level.
module codec_sport #(
   parameter int DATA_W      = 16,
   parameter int SHORT_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_sclk,
   input  logic              rx_fsync,
   input  logic              rx_sdata,
   input  logic              tx_sclk,
   input  logic              tx_fsync_in,
   input  logic              fs_internal,
   input  logic              wide_word,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   output logic              tx_sdata,
   output logic              tx_fsync_out,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_irq,
   output logic              tx_irq
);

   localparam int N_LINES = 5;

   generate
      if (SHORT_W < 2 || SHORT_W >= DATA_W) begin : g_bad_short
         $error("codec_sport: SHORT_W must lie in [2, DATA_W)");
      end
      if (DATA_W < 4) begin : g_bad_data
         $error("codec_sport: DATA_W too small");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] sync_lines;

   assign raw_lines = {tx_fsync_in, tx_sclk, rx_sdata, rx_fsync, rx_sclk};

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_sync
         csp_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_lines[g]),
            .lvl   (sync_lines[g])
         );
      end
   endgenerate

   csp_rx #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_lvl (sync_lines[0]),
      .fs_lvl   (sync_lines[1]),
      .din_lvl  (sync_lines[2]),
      .wide     (wide_word),
      .rx_word  (rx_word),
      .rx_done  (rx_irq)
   );

   csp_tx #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_lvl  (sync_lines[3]),
      .fs_lvl    (sync_lines[4]),
      .int_mode  (fs_internal),
      .wide      (wide_word),
      .wr        (tx_wr),
      .wdata     (tx_wdata),
      .dout      (tx_sdata),
      .fs_out    (tx_fsync_out),
      .load_done (tx_irq)
   );

   // R1: interrupts stay quiet in the cycle after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!rx_irq && !tx_irq));

endmodule

// File: tb/sim_codec_sport.sv
module sim_codec_sport;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        rfs = 1'b0, rdin = 1'b0, tfs = 1'b0;
   logic        fs_int = 1'b0, wide = 1'b1, wr = 1'b0;
   logic [15:0] wdata = 16'h0;
   logic        tx_sdata, tx_fsync_out, rx_irq, tx_irq;
   logic [15:0] rx_word;

   always #5 clk = ~clk;

   codec_sport u0 (
      .clk(clk), .rst_n(rst_n),
      .rx_sclk(sck), .rx_fsync(rfs), .rx_sdata(rdin),
      .tx_sclk(sck), .tx_fsync_in(tfs),
      .fs_internal(fs_int), .wide_word(wide),
      .tx_wr(wr), .tx_wdata(wdata),
      .tx_sdata(tx_sdata), .tx_fsync_out(tx_fsync_out),
      .rx_word(rx_word), .rx_irq(rx_irq), .tx_irq(tx_irq)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int rx_pulses = 0;
   int tx_pulses = 0;
   logic last_dout, last_fso;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // ---------------- behavioural reference model ----------------
   logic [2:0]  h_rc, h_rf, h_rd, h_tc, h_tf;   // [0] newest sample
   logic        r_act;
   int          r_cnt;
   logic [15:0] r_sh;
   int          t_st;                           // 0 idle, 1 sync, 2 shifting
   int          t_cnt;
   logic [15:0] t_sh, m_hold;
   logic [15:0] e_rx;
   logic        e_rxirq, e_txirq, e_dout, e_fs;

   always @(posedge clk) begin
      int   wl;
      logic rfall, trise, do_load;
      if (!rst_n) begin
         h_rc = 0; h_rf = 0; h_rd = 0; h_tc = 0; h_tf = 0;
         r_act = 0; r_cnt = 0; r_sh = 0;
         t_st = 0; t_cnt = 0; t_sh = 0; m_hold = 0;
         e_rx = 0; e_rxirq = 0; e_txirq = 0; e_dout = 0; e_fs = 0;
      end else begin
         wl      = wide ? 16 : 8;
         rfall   = h_rc[2] && !h_rc[1];
         trise   = h_tc[1] && !h_tc[2];
         e_rxirq = 0;
         e_txirq = 0;
         if (rfall) begin
            if (!r_act) begin
               if (h_rf[1]) begin r_act = 1; r_cnt = 0; end
            end else begin
               r_sh = {r_sh[14:0], h_rd[1]};
               if (r_cnt == wl - 1) begin
                  e_rx = wide ? r_sh : (r_sh & 16'h00FF);
                  e_rxirq = 1;
                  r_act = 0;
               end else r_cnt++;
            end
         end
         if (trise) begin
            do_load = 0;
            if (t_st == 1) do_load = 1;
            else if (t_st == 0 || (t_st == 2 && t_cnt == wl - 1)) begin
               if (fs_int) begin t_st = 1; e_fs = 1; e_dout = 0; end
               else if (h_tf[1]) do_load = 1;
               else begin t_st = 0; e_dout = 0; end
            end else begin
               t_sh = t_sh << 1;
               t_cnt++;
               e_dout = t_sh[wl-1];
            end
            if (do_load) begin
               t_sh = m_hold; t_cnt = 0; e_dout = m_hold[wl-1];
               e_txirq = 1; e_fs = 0; t_st = 2;
            end
         end
         if (wr) m_hold = wdata;
         h_rc = {h_rc[1:0], sck};
         h_rf = {h_rf[1:0], rfs};
         h_rd = {h_rd[1:0], rdin};
         h_tc = {h_tc[1:0], sck};
         h_tf = {h_tf[1:0], tfs};
      end
   end

   // per-cycle comparison against the model (R11 timing)
   always @(negedge clk) begin
      if (rst_n) begin
         check("R11", {rx_word, rx_irq, tx_irq, tx_sdata, tx_fsync_out},
                      {e_rx, e_rxirq, e_txirq, e_dout, e_fs}, "cycle match");
         if (rx_irq) rx_pulses++;
         if (tx_irq) tx_pulses++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic sck_cycle(input logic f_rx, input logic b_rx, input logic f_tx);
      sck = 1'b1; rfs = f_rx; rdin = b_rx; tfs = f_tx;
      repeat (4) @(negedge clk);
      last_dout = tx_sdata;
      last_fso  = tx_fsync_out;
      sck = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic frame(input logic [15:0] rw, input int len, input logic te,
                        output logic [15:0] tcap, output logic tail);
      tcap = 0;
      tail = 1'b1;
      for (int p = 0; p <= len; p++) begin
         if (p == 0) sck_cycle(1'b1, 1'b0, te);
         else        sck_cycle(1'b0, rw[len-p], 1'b0);
         if (p < len) tcap = {tcap[14:0], last_dout};
         else         tail = last_dout;
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic write_word(input logic [15:0] w);
      wdata = w; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   initial begin
      #3ms;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] cap;
      logic        tail;
      logic        fso_first, fso_second, fso_again;
      int          rxp, txp;

      repeat (5) @(negedge clk);
      check("R1", {rx_word, rx_irq, tx_irq, tx_sdata, tx_fsync_out}, 0, "reset outputs");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1", {rx_word, rx_irq, tx_irq, tx_sdata, tx_fsync_out}, 0, "idle after reset");

      // 16-bit, external sync
      write_word(16'hA5C3);
      rxp = rx_pulses; txp = tx_pulses;
      frame(16'h3C5A, 16, 1'b1, cap, tail);
      check("R2", rx_word, 16'h3C5A, "wide receive word");
      check("R4", rx_pulses - rxp, 1, "one receive pulse");
      check("R5", cap, 16'hA5C3, "wide transmit stream");
      check("R6", tx_pulses - txp, 1, "one transmit pulse");
      check("R10", tail, 1'b0, "dout idles after last bit");

      // no new write: repeat previous word
      txp = tx_pulses;
      frame(16'h8001, 16, 1'b1, cap, tail);
      check("R2", rx_word, 16'h8001, "second receive word");
      check("R7", cap, 16'hA5C3, "repeat of previous word");
      check("R6", tx_pulses - txp, 1, "pulse on repeated load");

      // 8-bit words
      wide = 1'b0;
      write_word(16'h12B7);
      frame(16'h00E4, 8, 1'b1, cap, tail);
      check("R3", rx_word, 16'h00E4, "short receive word");
      check("R9", cap[7:0], 8'hB7, "short transmit stream");
      check("R10", tail, 1'b0, "short frame tail");

      // receive only, no transmit sync: transmitter stays quiet
      txp = tx_pulses;
      frame(16'h005B, 8, 1'b0, cap, tail);
      check("R3", rx_word, 16'h005B, "short word without transmit");
      check("R5", tx_pulses - txp, 0, "no load without sync");
      check("R5", cap, 16'h0000, "dout quiet without sync");

      // internal sync, 16-bit
      wide = 1'b1;
      write_word(16'h6D29);
      fs_int = 1'b1;
      cap = 0;
      fso_first = 0; fso_second = 1; fso_again = 0;
      for (int p = 0; p <= 17; p++) begin
         sck_cycle(1'b0, 1'b0, 1'b0);
         if (p == 0)  fso_first = last_fso;
         if (p == 1)  fso_second = last_fso;
         if (p >= 1 && p <= 16) cap = {cap[14:0], last_dout};
         if (p == 17) fso_again = last_fso;
      end
      check("R8", fso_first, 1'b1, "generated sync high");
      check("R8", fso_second, 1'b0, "generated sync one period");
      check("R8", cap, 16'h6D29, "word after generated sync");
      check("R8", fso_again, 1'b1, "sync repeats after frame");
      fs_int = 1'b0;
      repeat (10) @(negedge clk);

      finish_run();
   end

endmodule